// File: doc/BRIEF.md
# Masked Output Macrocell Bank

This block is one bank of eight single-bit output registers inside a small programmable-logic fabric. Each register is normally loaded by fabric logic through a per-cell load strobe and data input. A host microcontroller can also write all eight cells at once over an 8-bit data bus. A per-bank protect mask blocks host writes to chosen cells. A masked cell keeps its value, or takes the fabric value if its fabric strobe is active. This lets some cells hold state-machine bits that the host must not disturb while the other cells stay writable.

Each cell can drive a pin or act only as an internal node. In the internal-node case the cell value still goes back into the logic array but the pin is never enabled. A pin cell either follows an output-enable equation or is enabled at all times. With an equation, its enable is the product-term input ORed with a host-written direction bit. The host can read back the cell values, the mask and the direction register at their own addresses.

Top module: `omc_bank`

## Requirements
- R1: While reset is applied and until the first write after it, the cells, the mask and the direction register all read 00h.
- R2: A host write to address 0 loads host_wdata[i] into every cell i whose mask bit is 0. The new value shows on fb_out on the clock edge that takes the write.
- R3: A host write to address 0 leaves every cell whose mask bit is 1 unchanged.
- R4: With the mask at 0Fh, a host write changes only cells 7..4, and cells 3..0 keep their values.
- R5: A cell with fab_load[i]=1 and no unmasked host write to it in that cycle loads fab_d[i], whatever its mask bit is.
- R6: In one cycle with both a host write and a fabric load, an unmasked cell takes the host bit and a masked cell takes the fabric bit.
- R7: For a cell with cfg_pin[i]=1 and cfg_has_oe[i]=1, pin_oe[i] = pt_oe[i] OR dir[i].
- R8: For a cell with cfg_pin[i]=1 and cfg_has_oe[i]=0, pin_oe[i] is 1 at all times, including during reset.
- R9: For a cell with cfg_pin[i]=0, pin_oe[i] and pin_out[i] are 0, and fb_out[i] still carries the cell value.
- R10: host_rdata is combinational on host_addr. Address 0 returns the cells, 1 the mask, 2 the direction register and 3 returns 00h. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Register select: 0 cells, 1 mask, 2 direction, 3 unused |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr |
| fab_load | input | 8 | Per-cell fabric load strobe |
| fab_d | input | 8 | Per-cell fabric data |
| pt_oe | input | 8 | Per-pin product-term output enable |
| cfg_pin | input | 8 | 1: cell drives its pin, 0: internal node only |
| cfg_has_oe | input | 8 | 1: pin uses the OE equation, 0: pin always enabled |
| pin_out | output | 8 | Pin data |
| pin_oe | output | 8 | Pin output enables |
| fb_out | output | 8 | Cell values fed back to the logic array |

## Verification
A host write and a fabric load can reach the same cell in the same cycle, and the mask decides which of the two wins. The stimulus table makes this happen with the mask at 0Fh and again with the mask at 00h. Host and fabric data are chosen so that each nibble shows which source won. After the clock edge, fb_out is compared with a split value built from the host nibble and the fabric nibble.

// File: rtl/omc_pkg.sv
package omc_pkg;
  typedef enum logic [1:0] {
    ADDR_CELL = 2'd0,
    ADDR_MASK = 2'd1,
    ADDR_DIR  = 2'd2,
    ADDR_RSVD = 2'd3
  } omc_addr_e;
endpackage

// File: rtl/omc_rst_sync.sv
module omc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/omc_ctrl_regs.sv
module omc_ctrl_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_sync_n,
  input  logic         mask_we,
  input  logic         dir_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] dir_q
);
  logic [W-1:0] mask_d;
  logic [W-1:0] dir_d;

  always_comb begin
    mask_d = mask_q;
    dir_d  = dir_q;
    if (mask_we) mask_d = wdata;
    if (dir_we)  dir_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mask_q <= '0;
      dir_q  <= '0;
    end else begin
      mask_q <= mask_d;
      dir_q  <= dir_d;
    end
  end
endmodule

// File: rtl/omc_cell.sv
module omc_cell (
  input  logic clk,
  input  logic rst_sync_n,
  input  logic host_wr,
  input  logic host_bit,
  input  logic protect,
  input  logic fab_ld,
  input  logic fab_bit,
  input  logic cfg_pin,
  input  logic cfg_has_oe,
  input  logic pt_oe,
  input  logic dir_bit,
  output logic q,
  output logic pin_out,
  output logic pin_oe
);
  logic q_d;
  logic q_en;
  logic host_take;

  always_comb begin
    host_take = host_wr & ~protect;
    q_en      = host_take | fab_ld;
    q_d       = host_take ? host_bit : fab_bit;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) q <= 1'b0;
    else if (q_en)   q <= q_d;
  end

  always_comb begin
    pin_out = cfg_pin & q;
    pin_oe  = cfg_pin & (cfg_has_oe ? (pt_oe | dir_bit) : 1'b1);
  end
endmodule

// File: rtl/omc_bank.sv
module omc_bank #(
  parameter int CELLS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [1:0]       host_addr,
  input  logic [CELLS-1:0] host_wdata,
  output logic [CELLS-1:0] host_rdata,
  input  logic [CELLS-1:0] fab_load,
  input  logic [CELLS-1:0] fab_d,
  input  logic [CELLS-1:0] pt_oe,
  input  logic [CELLS-1:0] cfg_pin,
  input  logic [CELLS-1:0] cfg_has_oe,
  output logic [CELLS-1:0] pin_out,
  output logic [CELLS-1:0] pin_oe,
  output logic [CELLS-1:0] fb_out
);
  import omc_pkg::*;

  logic             rst_sync_n;
  logic [CELLS-1:0] mask_q;
  logic [CELLS-1:0] dir_q;
  logic             cell_wr;
  logic             mask_wr;
  logic             dir_wr;
  omc_addr_e        addr;

  assign addr    = omc_addr_e'(host_addr);
  assign cell_wr = host_we && (addr == ADDR_CELL);
  assign mask_wr = host_we && (addr == ADDR_MASK);
  assign dir_wr  = host_we && (addr == ADDR_DIR);

  omc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  omc_ctrl_regs #(.W(CELLS)) u_regs (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .mask_we    (mask_wr),
    .dir_we     (dir_wr),
    .wdata      (host_wdata),
    .mask_q     (mask_q),
    .dir_q      (dir_q)
  );

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    omc_cell u_cell (
      .clk        (clk),
      .rst_sync_n (rst_sync_n),
      .host_wr    (cell_wr),
      .host_bit   (host_wdata[i]),
      .protect    (mask_q[i]),
      .fab_ld     (fab_load[i]),
      .fab_bit    (fab_d[i]),
      .cfg_pin    (cfg_pin[i]),
      .cfg_has_oe (cfg_has_oe[i]),
      .pt_oe      (pt_oe[i]),
      .dir_bit    (dir_q[i]),
      .q          (fb_out[i]),
      .pin_out    (pin_out[i]),
      .pin_oe     (pin_oe[i])
    );
  end

  always_comb begin
    unique case (addr)
      ADDR_CELL: host_rdata = fb_out;
      ADDR_MASK: host_rdata = mask_q;
      ADDR_DIR:  host_rdata = dir_q;
      default:   host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/omc_bank_chk.sv
module omc_bank_chk #(
  parameter int CELLS = 8
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             host_we,
  input logic [1:0]       host_addr,
  input logic [CELLS-1:0] host_wdata,
  input logic [CELLS-1:0] mask_q,
  input logic [CELLS-1:0] fab_load,
  input logic [CELLS-1:0] fab_d,
  input logic [CELLS-1:0] pt_oe,
  input logic [CELLS-1:0] cfg_pin,
  input logic [CELLS-1:0] cfg_has_oe,
  input logic [CELLS-1:0] pin_oe,
  input logic [CELLS-1:0] pin_out,
  input logic [CELLS-1:0] fb_out
);
  // R2: unmasked cells follow a host write
  a_r2_host_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_we && host_addr == 2'd0) |=>
      ((fb_out & ~$past(mask_q)) == ($past(host_wdata) & ~$past(mask_q))));

  // R3: masked cells without a fabric load keep their value
  a_r3_masked_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_we && host_addr == 2'd0) |=>
      ((fb_out & $past(mask_q) & ~$past(fab_load)) ==
       ($past(fb_out) & $past(mask_q) & ~$past(fab_load))));

  // R5: fabric loads land when the host is idle
  a_r5_fab_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!host_we) |=> ((fb_out & $past(fab_load)) == ($past(fab_d) & $past(fab_load))));

  // R7: an active product term always enables an equation pin
  a_r7_pt_enables: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((cfg_pin & cfg_has_oe & pt_oe & ~pin_oe) == '0));

  // R8: default-enable pins are always on
  a_r8_default_on: assert property (@(posedge clk)
    ((cfg_pin & ~cfg_has_oe & ~pin_oe) == '0));

  // R9: internal nodes never drive their pin
  a_r9_internal_quiet: assert property (@(posedge clk)
    (((~cfg_pin & pin_oe) | (~cfg_pin & pin_out)) == '0));
endmodule

bind omc_bank omc_bank_chk #(.CELLS(CELLS)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .host_we    (host_we),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .mask_q     (mask_q),
  .fab_load   (fab_load),
  .fab_d      (fab_d),
  .pt_oe      (pt_oe),
  .cfg_pin    (cfg_pin),
  .cfg_has_oe (cfg_has_oe),
  .pin_oe     (pin_oe),
  .pin_out    (pin_out),
  .fb_out     (fb_out)
);

// File: tb/tb_omc_bank.sv
module tb_omc_bank;
  logic       clk;
  logic       rst_n;
  logic       host_we;
  logic [1:0] host_addr;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic [7:0] fab_load;
  logic [7:0] fab_d;
  logic [7:0] pt_oe;
  logic [7:0] cfg_pin;
  logic [7:0] cfg_has_oe;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;
  logic [7:0] fb_out;

  int n_vec;
  int n_bad;

  omc_bank dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .fab_load(fab_load),
    .fab_d(fab_d), .pt_oe(pt_oe), .cfg_pin(cfg_pin), .cfg_has_oe(cfg_has_oe),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {we, addr, wdata, fab_load, fab_d, expected fb_out after the edge}
  localparam int NV = 12;
  localparam logic [34:0] VEC [NV] = '{
    {1'b1, 2'd0, 8'hFF, 8'h00, 8'h00, 8'hFF},  // R2
    {1'b1, 2'd0, 8'h5A, 8'h00, 8'h00, 8'h5A},  // R2
    {1'b1, 2'd1, 8'h0F, 8'h00, 8'h00, 8'h5A},  // mask = 0F
    {1'b1, 2'd0, 8'h00, 8'h00, 8'h00, 8'h0A},  // R3 R4
    {1'b1, 2'd0, 8'hFF, 8'h00, 8'h00, 8'hFA},  // R3 R4
    {1'b0, 2'd0, 8'h00, 8'hFF, 8'h00, 8'h00},  // R5
    {1'b0, 2'd0, 8'h00, 8'h0F, 8'h05, 8'h05},  // R5 masked cells
    {1'b1, 2'd0, 8'h30, 8'hFF, 8'hC9, 8'h39},  // R6 split
    {1'b1, 2'd1, 8'h00, 8'h00, 8'h00, 8'h39},  // mask = 00
    {1'b1, 2'd0, 8'hA5, 8'hFF, 8'h5A, 8'hA5},  // R6 host wins
    {1'b1, 2'd2, 8'h81, 8'h00, 8'h00, 8'hA5},  // dir = 81
    {1'b1, 2'd3, 8'h00, 8'h00, 8'h00, 8'hA5}   // R10 reserved write
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    host_addr = a;
    #1;
    check(req, host_rdata, exp);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0; n_bad = 0;
    rst_n = 1'b0; host_we = 1'b0; host_addr = 2'd0; host_wdata = '0;
    fab_load = '0; fab_d = '0; pt_oe = '0; cfg_pin = 8'hFF; cfg_has_oe = 8'h00;
    repeat (3) @(negedge clk);
    check("R8 during reset", pin_oe, 8'hFF);
    check("R1 cells in reset", fb_out, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_chk("R1 cells", 2'd0, 8'h00);
    read_chk("R1 mask", 2'd1, 8'h00);
    read_chk("R1 dir", 2'd2, 8'h00);

    for (int k = 0; k < NV; k++) begin
      {host_we, host_addr, host_wdata, fab_load, fab_d} = VEC[k][34:8];
      @(negedge clk);
      host_we = 1'b0; fab_load = '0;
      check($sformatf("R2-R6 vector %0d", k), fb_out, VEC[k][7:0]);
    end

    read_chk("R10 cells", 2'd0, 8'hA5);
    read_chk("R10 mask", 2'd1, 8'h00);
    read_chk("R10 dir", 2'd2, 8'h81);
    read_chk("R10 reserved", 2'd3, 8'h00);

    cfg_has_oe = 8'hFF; pt_oe = 8'h00; #1;
    check("R7 dir only", pin_oe, 8'h81);
    pt_oe = 8'h18; #1;
    check("R7 pt or dir", pin_oe, 8'h99);
    pt_oe = 8'h00; cfg_has_oe = 8'h0F; #1;
    check("R8 default on", pin_oe, 8'hF1);
    cfg_pin = 8'h0F; #1;
    check("R9 oe off", pin_oe, 8'h01);
    check("R9 pin data", pin_out, 8'h05);
    check("R9 feedback", fb_out, 8'hA5);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset cells", fb_out, 8'h00);
    read_chk("R1 re-reset dir", 2'd2, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule